// File: doc/BRIEF.md
# Interrupt-Exit Context Restore Sequencer

This block carries out the tail end of a compressed "leave the interrupt handler and return" operation on a 32-bit core. A single `start` pulse hands it the current stack pointer, the live NMI-enable bit and the live value of the core's vendor cause/status CSR. It then walks a fixed frame below the stack pointer with one 32-bit read at a time. Each loaded word goes into an integer register or into the cause CSR. The stacked cause word is merged with the live pending and exception bits before it is written back.

Once the loads are done, the block raises the stack pointer by the frame size. It unpacks the previous-enable, previous-trap-disable and previous-level fields and sends them to one of two status paths. The regular-interrupt path is used when NMI-enable was 1, and the NMI path when it was 0. The block then rewrites the cause CSR with those fields cleared, presents the PC redirect and signals completion. If a read returns an error, the sequence stops and the stack pointer and PC are left alone.

The top word of the frame, at sp−4, holds a previous return PC. The sequencer does not fetch it.

Top module: `irq_exit_restore`

## Requirements
- R1: After reset, `mem_req_valid`, every write strobe (`rf_we`, `cause_we`, `irq_stat_we`, `nmi_stat_we`, `pc_we`), `done` and `err` are 0.
- R2: After `start`, exactly 18 reads are issued, one at a time, at these addresses:
  - sp−12 (cause CSR), then sp−8 (x8), then sp−16 (x1);
  - then sp−24, sp−28 and so on in 4-byte steps down to sp−80, targeting x5, x6, x7, x10 to x17 and x28 to x31 in that order.
  - The word at sp−4 is never read.
- R3: At most one read is outstanding: a new request appears only after the previous response. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold steady.
- R4: The cycle after a good response to a register slot, `rf_we` is 1 with that slot's register index and the loaded data. x0 is never written.
- R5: The cycle after the response to the cause slot, `cause_we` is 1. Bits 24 and 25 of the written value come from `cause_live_in` as sampled at `start`, and all other bits come from the loaded word.
- R6: After the last load, x2 is written with the sampled sp plus `FRAME_BYTES` (96 by default). This happens before any status write.
- R7: When the sampled NMI-enable is 1, the regular path is taken:
  - `irq_stat_we` pulses with `prev_ie` = merged bit 27, `prev_dt` = bit 29 and `prev_lvl` = bits 19:16;
  - the cause CSR is rewritten as the merged value with bits 26, 27, 29 and 19:12 cleared;
  - `pc_wdata` is `epc_in`.
- R8: When the sampled NMI-enable is 0, the NMI path is taken:
  - `nmi_stat_we` pulses with `prev_ie` = merged bit 28, `prev_lvl` = bits 23:20, `mie_wdata` = bit 28 and `prev_dt` = 0;
  - the cause CSR is rewritten as the merged value with bits 26, 28, 30, 15:12 and 23:20 cleared;
  - `pc_wdata` is `nmi_epc_in`.
- R9: The path and the live bits are taken from the inputs at `start`. Later changes to `nmi_en_in` or `cause_live_in` have no effect, and at most one status strobe is high at a time.
- R10: `done` pulses for one cycle, on the cycle right after the `pc_we` cycle.
- R11: A response with `mem_rsp_err` = 1 gives a one-cycle `err` pulse the cycle after. No further requests, x2 write, status write, `pc_we` or `done` follow.
- R12: A `start` pulse while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a restore sequence (accepted when idle) |
| sp_in | input | 32 | Current stack pointer |
| nmi_en_in | input | 1 | Live NMI-enable bit (1 selects the regular path) |
| cause_live_in | input | 32 | Live cause CSR value before the restore |
| epc_in | input | 32 | Regular exception return address |
| nmi_epc_in | input | 32 | NMI return address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| rf_we | output | 1 | Integer register write strobe |
| rf_waddr | output | 5 | Integer register index |
| rf_wdata | output | 32 | Integer register data |
| cause_we | output | 1 | Cause CSR write strobe |
| cause_wdata | output | 32 | Cause CSR write data |
| irq_stat_we | output | 1 | Regular-path status write strobe |
| nmi_stat_we | output | 1 | NMI-path status write strobe |
| prev_ie | output | 1 | Previous interrupt-enable value |
| prev_dt | output | 1 | Previous trap-disable value (regular path) |
| prev_lvl | output | 4 | Previous interrupt level |
| mie_wdata | output | 1 | Machine interrupt-enable value (NMI path) |
| pc_we | output | 1 | PC redirect strobe |
| pc_wdata | output | 32 | PC redirect target |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Sequence aborted on a read error |

## Verification
The bench builds the block with its default frame size of 96 bytes, so the x2 result and the 18-slot frame layout can be checked against fixed expectations. It puts this against a responder whose ready and latency vary pseudo-randomly. That brings request holding under back-pressure and back-to-back versus delayed responses within reach. Runs cover both NMI-enable values against all four combinations of live bits 24 and 25, with stacked bits set opposite to the live ones. Further runs inject an error in mid-frame and pulse `start` during a sequence.

// File: rtl/irq_exit_pkg.sv
package irq_exit_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_LOADS = 18;
    localparam int STEP_W    = $clog2(NUM_LOADS);

    // bits kept from the live cause value (pending NMI, exception)
    localparam logic [XLEN-1:0] LIVE_KEEP = 32'h0300_0000;
    // cleared on regular exit: 29, 27, 26, 19:12
    localparam logic [XLEN-1:0] IRQ_CLEAR = 32'h2C0F_F000;
    // cleared on NMI exit: 30, 28, 26, 23:20, 15:12
    localparam logic [XLEN-1:0] NMI_CLEAR = 32'h54F0_F000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SP,
        ST_STAT,
        ST_PC,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       to_cause;
        logic [4:0] rd;
        logic [6:0] below;
    } slot_t;

    function automatic slot_t slot_of(input logic [STEP_W-1:0] step);
        slot_t s;
        int    k;
        k          = int'(step);
        s.to_cause = 1'b0;
        s.rd       = 5'd0;
        s.below    = 7'd0;
        if (k == 0) begin
            s.to_cause = 1'b1;
            s.below    = 7'd12;
        end else if (k == 1) begin
            s.rd    = 5'd8;
            s.below = 7'd8;
        end else if (k == 2) begin
            s.rd    = 5'd1;
            s.below = 7'd16;
        end else begin
            s.below = 7'(12 + 4 * k);
            if (k < 6)       s.rd = 5'(k + 2);
            else if (k < 14) s.rd = 5'(k + 4);
            else             s.rd = 5'(k + 14);
        end
        return s;
    endfunction

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [XLEN-1:0]   sp;
        logic              nmi_en;
        logic [XLEN-1:0]   live;
        logic [XLEN-1:0]   merged;
        logic              rf_we;
        logic [4:0]        rf_waddr;
        logic [XLEN-1:0]   rf_wdata;
        logic              cause_we;
        logic [XLEN-1:0]   cause_wdata;
        logic              irq_stat_we;
        logic              nmi_stat_we;
        logic              prev_ie;
        logic              prev_dt;
        logic [3:0]        prev_lvl;
        logic              mie;
        logic              pc_we;
        logic [XLEN-1:0]   pc_wdata;
        logic              done;
        logic              err;
    } seq_reg_t;

endpackage

// File: rtl/irq_exit_frame.sv
module irq_exit_frame
    import irq_exit_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [XLEN-1:0]   sp_i,
    output logic [XLEN-1:0]   addr_o,
    output logic              to_cause_o,
    output logic [4:0]        rd_o,
    output logic              last_o
);
    slot_t slot;

    always_comb begin
        slot       = slot_of(step_i);
        addr_o     = sp_i - XLEN'(slot.below);
        to_cause_o = slot.to_cause;
        rd_o       = slot.rd;
        last_o     = (int'(step_i) == NUM_LOADS - 1);
    end
endmodule

// File: rtl/irq_exit_cause_merge.sv
module irq_exit_cause_merge
    import irq_exit_pkg::*;
(
    input  logic [XLEN-1:0] stacked_i,
    input  logic [XLEN-1:0] live_i,
    output logic [XLEN-1:0] merged_o
);
    always_comb begin
        merged_o = (stacked_i & ~LIVE_KEEP) | (live_i & LIVE_KEEP);
    end
endmodule

// File: rtl/irq_exit_cause_unpack.sv
module irq_exit_cause_unpack
    import irq_exit_pkg::*;
(
    input  logic [XLEN-1:0] merged_i,
    input  logic            irq_path_i,
    output logic [XLEN-1:0] masked_o,
    output logic            prev_ie_o,
    output logic            prev_dt_o,
    output logic [3:0]      prev_lvl_o,
    output logic            mie_o
);
    always_comb begin
        if (irq_path_i) begin
            masked_o   = merged_i & ~IRQ_CLEAR;
            prev_ie_o  = merged_i[27];
            prev_dt_o  = merged_i[29];
            prev_lvl_o = merged_i[19:16];
            mie_o      = 1'b0;
        end else begin
            masked_o   = merged_i & ~NMI_CLEAR;
            prev_ie_o  = merged_i[28];
            prev_dt_o  = 1'b0;
            prev_lvl_o = merged_i[23:20];
            mie_o      = merged_i[28];
        end
    end
endmodule

// File: rtl/irq_exit_restore.sv
module irq_exit_restore
    import irq_exit_pkg::*;
#(
    parameter int FRAME_BYTES = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] sp_in,
    input  logic        nmi_en_in,
    input  logic [31:0] cause_live_in,
    input  logic [31:0] epc_in,
    input  logic [31:0] nmi_epc_in,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    input  logic        mem_rsp_err,
    output logic        rf_we,
    output logic [4:0]  rf_waddr,
    output logic [31:0] rf_wdata,
    output logic        cause_we,
    output logic [31:0] cause_wdata,
    output logic        irq_stat_we,
    output logic        nmi_stat_we,
    output logic        prev_ie,
    output logic        prev_dt,
    output logic [3:0]  prev_lvl,
    output logic        mie_wdata,
    output logic        pc_we,
    output logic [31:0] pc_wdata,
    output logic        done,
    output logic        err
);
    localparam logic [XLEN-1:0] SP_BUMP = XLEN'(FRAME_BYTES);

    seq_reg_t q, d;

    logic [XLEN-1:0] slot_addr;
    logic            slot_cause;
    logic [4:0]      slot_rd;
    logic            slot_last;
    logic [XLEN-1:0] merged_now;
    logic [XLEN-1:0] masked_now;
    logic            f_ie, f_dt, f_mie;
    logic [3:0]      f_lvl;

    irq_exit_frame u_frame (
        .step_i     (q.step),
        .sp_i       (q.sp),
        .addr_o     (slot_addr),
        .to_cause_o (slot_cause),
        .rd_o       (slot_rd),
        .last_o     (slot_last)
    );

    irq_exit_cause_merge u_merge (
        .stacked_i (mem_rsp_data),
        .live_i    (q.live),
        .merged_o  (merged_now)
    );

    irq_exit_cause_unpack u_unpack (
        .merged_i   (q.merged),
        .irq_path_i (q.nmi_en),
        .masked_o   (masked_now),
        .prev_ie_o  (f_ie),
        .prev_dt_o  (f_dt),
        .prev_lvl_o (f_lvl),
        .mie_o      (f_mie)
    );

    always_comb begin
        d             = q;
        d.rf_we       = 1'b0;
        d.cause_we    = 1'b0;
        d.irq_stat_we = 1'b0;
        d.nmi_stat_we = 1'b0;
        d.pc_we       = 1'b0;
        d.done        = 1'b0;
        d.err         = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state  = ST_REQ;
                    d.step   = '0;
                    d.sp     = sp_in;
                    d.nmi_en = nmi_en_in;
                    d.live   = cause_live_in;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        d.err   = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        if (slot_cause) begin
                            d.cause_we    = 1'b1;
                            d.cause_wdata = merged_now;
                            d.merged      = merged_now;
                        end else begin
                            d.rf_we    = 1'b1;
                            d.rf_waddr = slot_rd;
                            d.rf_wdata = mem_rsp_data;
                        end
                        if (slot_last) begin
                            d.state = ST_SP;
                        end else begin
                            d.step  = q.step + 1'b1;
                            d.state = ST_REQ;
                        end
                    end
                end
            end
            ST_SP: begin
                d.rf_we    = 1'b1;
                d.rf_waddr = 5'd2;
                d.rf_wdata = q.sp + SP_BUMP;
                d.state    = ST_STAT;
            end
            ST_STAT: begin
                d.cause_we    = 1'b1;
                d.cause_wdata = masked_now;
                d.irq_stat_we = q.nmi_en;
                d.nmi_stat_we = ~q.nmi_en;
                d.prev_ie     = f_ie;
                d.prev_dt     = f_dt;
                d.prev_lvl    = f_lvl;
                d.mie         = f_mie;
                d.state       = ST_PC;
            end
            ST_PC: begin
                d.pc_we    = 1'b1;
                d.pc_wdata = q.nmi_en ? epc_in : nmi_epc_in;
                d.state    = ST_DONE;
            end
            ST_DONE: begin
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid = (q.state == ST_REQ);
    assign mem_req_addr  = slot_addr;
    assign rf_we         = q.rf_we;
    assign rf_waddr      = q.rf_waddr;
    assign rf_wdata      = q.rf_wdata;
    assign cause_we      = q.cause_we;
    assign cause_wdata   = q.cause_wdata;
    assign irq_stat_we   = q.irq_stat_we;
    assign nmi_stat_we   = q.nmi_stat_we;
    assign prev_ie       = q.prev_ie;
    assign prev_dt       = q.prev_dt;
    assign prev_lvl      = q.prev_lvl;
    assign mie_wdata     = q.mie;
    assign pc_we         = q.pc_we;
    assign pc_wdata      = q.pc_wdata;
    assign done          = q.done;
    assign err           = q.err;

    assert_req_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_no_x0_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0));

    assert_sp_before_stat_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == 5'd2) |=> (irq_stat_we || nmi_stat_we));

    assert_one_path_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_stat_we, nmi_stat_we}));

    assert_done_after_pc_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pc_we));

    assert_err_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!pc_we && !done && !mem_req_valid));

    assert_err_then_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!mem_req_valid && !rf_we && !pc_we));

endmodule

// File: tb/sim_irq_exit_restore.sv
module sim_irq_exit_restore;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] sp_in = '0;
    logic        nmi_en_in = 1'b0;
    logic [31:0] cause_live_in = '0;
    logic [31:0] epc_in = '0;
    logic [31:0] nmi_epc_in = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        cause_we;
    logic [31:0] cause_wdata;
    logic        irq_stat_we, nmi_stat_we, prev_ie, prev_dt, mie_wdata;
    logic [3:0]  prev_lvl;
    logic        pc_we;
    logic [31:0] pc_wdata;
    logic        done, err;

    always #2.5 clk = ~clk;

    irq_exit_restore u0 (.*);

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem [0:63];
    logic [31:0] q_addr [$];
    logic [36:0] q_rf [$];
    logic [31:0] q_cause [$];

    bit          exp_irq, exp_ie, exp_dt, exp_mie, exp_err;
    logic [3:0]  exp_lvl;
    logic [31:0] exp_pc;
    bit          err_on = 0;
    logic [31:0] err_addr = '0;
    bit          got_done, got_err, got_pc;

    int slot_off [18] = '{12, 8, 16, 24, 28, 32, 36, 40, 44, 48, 52, 56, 60, 64, 68, 72, 76, 80};
    int slot_rd  [18] = '{0, 8, 1, 5, 6, 7, 10, 11, 12, 13, 14, 15, 16, 17, 28, 29, 30, 31};

    function automatic int idx(input logic [31:0] a);
        return int'((a - 32'h0F00) >> 2) & 63;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // observer, reference comparison and memory responder, all at the falling edge
    initial begin
        logic [36:0] e;
        logic [31:0] ec;
        bit          pc_prev;
        bit          pending, took, prev_stall;
        int          cnt;
        logic [31:0] paddr, took_addr, prev_addr;
        logic [15:0] lfsr;
        pc_prev = 0; pending = 0; took = 0; cnt = 0; prev_stall = 0;
        paddr = '0; took_addr = '0; prev_addr = '0; lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rf_we) begin
                    if (q_rf.size() == 0) chk(0, "R4 unexpected register write", {27'd0, rf_waddr}, 0);
                    else begin
                        e = q_rf.pop_front();
                        chk({rf_waddr, rf_wdata} == e, (e[36:32] == 5'd2) ? "R6 sp write" : "R4 register write",
                            rf_wdata, e[31:0]);
                        chk(rf_waddr == e[36:32], "R4 register index", {27'd0, rf_waddr}, {27'd0, e[36:32]});
                    end
                end
                if (cause_we) begin
                    if (q_cause.size() == 0) chk(0, "R5 unexpected cause write", cause_wdata, 0);
                    else begin
                        ec = q_cause.pop_front();
                        chk(cause_wdata == ec, (q_cause.size() == 0 && !exp_err) ? "R7/R8 cause rewrite" : "R5 cause merge",
                            cause_wdata, ec);
                    end
                end
                if (irq_stat_we) begin
                    chk(exp_irq && !exp_err, "R9 regular path strobe", 1, {31'd0, exp_irq});
                    chk(prev_ie == exp_ie, "R7 prev_ie", {31'd0, prev_ie}, {31'd0, exp_ie});
                    chk(prev_dt == exp_dt, "R7 prev_dt", {31'd0, prev_dt}, {31'd0, exp_dt});
                    chk(prev_lvl == exp_lvl, "R7 prev_lvl", {28'd0, prev_lvl}, {28'd0, exp_lvl});
                end
                if (nmi_stat_we) begin
                    chk(!exp_irq && !exp_err, "R9 nmi path strobe", 1, {31'd0, !exp_irq});
                    chk(prev_ie == exp_ie, "R8 prev_ie", {31'd0, prev_ie}, {31'd0, exp_ie});
                    chk(prev_dt == 1'b0, "R8 prev_dt", {31'd0, prev_dt}, 0);
                    chk(prev_lvl == exp_lvl, "R8 prev_lvl", {28'd0, prev_lvl}, {28'd0, exp_lvl});
                    chk(mie_wdata == exp_mie, "R8 mie", {31'd0, mie_wdata}, {31'd0, exp_mie});
                end
                if (pc_we) begin
                    got_pc = 1;
                    chk(!exp_err, "R11 pc after error", 1, 0);
                    chk(pc_wdata == exp_pc, exp_irq ? "R7 pc target" : "R8 pc target", pc_wdata, exp_pc);
                end
                if (done) begin
                    got_done = 1;
                    chk(pc_prev, "R10 done follows pc", {31'd0, pc_prev}, 1);
                end
                if (err) got_err = 1;
                pc_prev = pc_we;

                // request holding under back-pressure
                if (prev_stall) chk(mem_req_valid && mem_req_addr == prev_addr, "R3 request hold", mem_req_addr, prev_addr);
                if (pending && mem_req_valid) chk(0, "R3 overlapping request", mem_req_addr, 0);
            end

            // responder
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (took) begin
                pending = 1; paddr = took_addr; took = 0;
                cnt = int'(lfsr[5:4]) % 3;
            end
            if (pending) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[idx(paddr)];
                    mem_rsp_err   = err_on && (paddr == err_addr);
                    pending = 0;
                end else cnt--;
            end
            mem_req_ready = lfsr[0] | lfsr[3];
            prev_stall = rst_n && mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                took = 1; took_addr = mem_req_addr;
                if (q_addr.size() == 0) chk(0, "R2/R11 unexpected request", mem_req_addr, 0);
                else begin
                    ec = q_addr.pop_front();
                    chk(mem_req_addr == ec, "R2 read address", mem_req_addr, ec);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                finished = 1;
                errors++; checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic run(input bit nmi, input logic [31:0] live, input logic [31:0] stk,
                       input int seed, input int err_step, input bit poke);
        logic [31:0] sp, merged, clr;
        int          n_addr, n_wr, t;
        sp = 32'h0000_1000;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(seed * 256 + i * 7);
        mem[idx(sp - 12)] = stk;
        merged = (stk & ~((32'd1 << 24) | (32'd1 << 25))) | (live & ((32'd1 << 24) | (32'd1 << 25)));
        exp_err = (err_step >= 0);
        n_addr  = exp_err ? err_step + 1 : 18;
        n_wr    = exp_err ? err_step : 18;
        for (int i = 0; i < n_addr; i++) q_addr.push_back(sp - 32'(slot_off[i]));
        for (int i = 0; i < n_wr; i++) begin
            if (i == 0) q_cause.push_back(merged);
            else q_rf.push_back({5'(slot_rd[i]), mem[idx(sp - 32'(slot_off[i]))]});
        end
        exp_irq = nmi;
        if (nmi) begin
            clr = (32'd1 << 26) | (32'd1 << 27) | (32'd1 << 29) | (32'hFF << 12);
            exp_ie = merged[27]; exp_dt = merged[29]; exp_lvl = merged[19:16]; exp_mie = 0;
            exp_pc = 32'h8000_0100 + 32'(seed);
        end else begin
            clr = (32'd1 << 26) | (32'd1 << 28) | (32'd1 << 30) | (32'hF << 12) | (32'hF << 20);
            exp_ie = merged[28]; exp_dt = 0; exp_lvl = merged[23:20]; exp_mie = merged[28];
            exp_pc = 32'h9000_0200 + 32'(seed);
        end
        if (!exp_err) begin
            q_rf.push_back({5'd2, sp + 32'd96});
            q_cause.push_back(merged & ~clr);
        end
        err_on   = exp_err;
        err_addr = exp_err ? sp - 32'(slot_off[err_step]) : '0;
        got_done = 0; got_err = 0; got_pc = 0;

        @(negedge clk);
        sp_in = sp; nmi_en_in = nmi; cause_live_in = live;
        epc_in = 32'h8000_0100 + 32'(seed); nmi_epc_in = 32'h9000_0200 + 32'(seed);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nmi_en_in = ~nmi; cause_live_in = ~live;   // R9: must be ignored
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1; sp_in = 32'h0000_1040;     // R12: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!got_done && !got_err && t < 800) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        if (exp_err) begin
            chk(got_err, "R11 err pulse", {31'd0, got_err}, 1);
            chk(!got_done && !got_pc, "R11 no done or pc", {30'd0, got_done, got_pc}, 0);
        end else begin
            chk(got_done, "R10 done seen", {31'd0, got_done}, 1);
            chk(!got_err, "R11 no spurious err", {31'd0, got_err}, 0);
        end
        chk(q_addr.size() == 0, poke ? "R12 read count" : "R2 read count", 32'(q_addr.size()), 0);
        chk(q_rf.size() == 0, "R4 register write count", 32'(q_rf.size()), 0);
        chk(q_cause.size() == 0, "R5 cause write count", 32'(q_cause.size()), 0);
        q_addr.delete(); q_rf.delete(); q_cause.delete();
        err_on = 0;
    endtask

    initial begin
        logic [31:0] live, stk;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid && !rf_we && !cause_we && !irq_stat_we && !nmi_stat_we && !pc_we && !done && !err,
            "R1 reset state",
            {24'd0, mem_req_valid, rf_we, cause_we, irq_stat_we, nmi_stat_we, pc_we, done, err}, 0);

        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++) begin
                live = (32'h1234_5678 & ~32'h0300_0000) | (32'(k) << 24);
                stk  = ((32'hFEDC_BA98 ^ (32'h1111_1111 * 32'(k + 4 * p))) & ~32'h0300_0000) | (32'(3 - k) << 24);
                run(p == 0, live, stk, k + 4 * p, -1, 0);
            end
        end
        run(1'b1, 32'h0, 32'hFFFF_FFFF, 9, -1, 0);
        run(1'b0, 32'h0, 32'hFFFF_FFFF, 10, -1, 0);
        run(1'b0, 32'h0300_0000, 32'h0000_0000, 11, -1, 0);
        run(1'b1, 32'h0100_0000, 32'h5A5A_A5A5, 12, 5, 0);
        run(1'b0, 32'h0200_0000, 32'h1357_9BDF, 13, -1, 1);
        run(1'b1, 32'h0300_0000, 32'hC0FF_EE00, 14, -1, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule